// File: doc/BRIEF.md
# Profile Select Tuning Word Loader

This block keeps four 32-bit frequency tuning words, one per profile, and feeds the chosen one to a phase accumulator. The accumulator adds that word on every clock and wraps modulo 2^32, so its output is a running phase ramp whose slope is set by the active word. Software-side logic fills the four profile slots through a simple write port. Two select pins pick the profile, and their weighting is deliberately unusual.

There are two ways a word becomes active. A change on the select pins loads the newly chosen profile's word at once, with no extra action. Rewriting the word of the profile that is already selected does nothing visible until an update strobe arrives, and that strobe is honoured only in single-tone mode. Outside single-tone mode the strobe input is ignored. In that mode the block instead emits a one-cycle data pacing pulse at a fixed divided rate, which a sample source can use to time its words.

Both the select pins and the strobe are asynchronous to the block clock. Each passes through a synchronizer chain, and the strobe is edge-detected so that a long pulse still counts once.

Top module: `profile_tuning_loader`

## Requirements
- R1: While reset is high and just after it, activeTw, phaseOut and dataPace are 0, and every profile slot holds 0.
- R2: The selected profile index is 2*selHigh + selLow, so selLow carries weight 1 and selHigh carries weight 2.
- R3: When the select pins change to a new profile, activeTw shows that profile's stored word from the third rising clock edge after the change, with no update strobe, in either mode.
- R4: A write of a new word into the currently selected profile leaves activeTw unchanged until a commit happens.
- R5: In single-tone mode (singleTone=1), a rising edge on updIn copies the selected profile's stored word to activeTw by the third rising clock edge.
- R6: updIn held high for many cycles causes exactly one commit. A word written while it stays high does not become active until updIn falls and rises again.
- R7: With singleTone=0, pulses on updIn have no effect on activeTw.
- R8: On every clock, phaseOut advances by the activeTw value of the previous cycle, modulo 2^32.
- R9: With singleTone=0, dataPace is a one-cycle pulse that occurs exactly once in every PACE_DIV cycles (default 4). With singleTone=1 it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Asynchronous reset, active high |
| wrEn | input | 1 | Profile word write enable |
| wrAddr | input | 2 | Profile slot to write |
| wrData | input | 32 | Tuning word to store |
| selLow | input | 1 | Profile select, weight 1 (asynchronous) |
| selHigh | input | 1 | Profile select, weight 2 (asynchronous) |
| singleTone | input | 1 | Single-tone mode when high |
| updIn | input | 1 | Frequency update strobe (asynchronous) |
| dataPace | output | 1 | Data pacing pulse when singleTone is low |
| activeTw | output | 32 | Tuning word currently driving the accumulator |
| phaseOut | output | 32 | Phase accumulator value |

## Verification
A wrong active word, whether it comes from a missed commit, a spurious commit or swapped select weights, shows up directly on activeTw. It also shows up in the slope of phaseOut one cycle later. The bench therefore compares the word and the per-cycle phase step after each stimulus. A synchronizer or edge detector that loses or repeats events appears within three or four cycles as a word that should or should not have changed. A faulty pacing counter shows up as the wrong number of pulses within one PACE_DIV window.

// File: rtl/prof_loader_pkg.sv
package profLoaderPkg;
  localparam int NUM_PROFILES = 4;
  localparam int PROF_IDX_W   = $clog2(NUM_PROFILES);

  typedef struct packed {
    logic                  loadActive;
    logic [PROF_IDX_W-1:0] profIdx;
  } ctrlStrobe_t;
endpackage

// File: rtl/prof_ctrl.sv
module profCtrl
  import profLoaderPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PACE_DIV    = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        selLow,
  input  logic        selHigh,
  input  logic        singleTone,
  input  logic        updIn,
  output ctrlStrobe_t strobe,
  output logic        dataPace
);
  localparam int PACE_W = (PACE_DIV > 1) ? $clog2(PACE_DIV) : 1;
  localparam logic [PACE_W-1:0] PACE_LAST = PACE_W'(PACE_DIV - 1);

  logic [PROF_IDX_W-1:0] selPipe [SYNC_STAGES];
  logic [SYNC_STAGES:0]  updPipe;
  logic [PROF_IDX_W-1:0] selSync, curProfile;
  logic                  updSync, updPrev, updRise, profChange;
  logic [PACE_W-1:0]     paceCnt;

  // selHigh has weight 2 and selLow weight 1 (R2)
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) selPipe[i] <= '0;
      updPipe <= '0;
    end else begin
      selPipe[0] <= {selHigh, selLow};
      for (int i = 1; i < SYNC_STAGES; i++) selPipe[i] <= selPipe[i-1];
      updPipe <= {updPipe[SYNC_STAGES-1:0], updIn};
    end
  end

  assign selSync = selPipe[SYNC_STAGES-1];
  assign updSync = updPipe[SYNC_STAGES-1];
  assign updPrev = updPipe[SYNC_STAGES];

  // One commit per rising edge, only in single-tone mode (R5, R6, R7)
  assign updRise    = updSync & ~updPrev & singleTone;
  assign profChange = (selSync != curProfile);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) curProfile <= '0;
    else     curProfile <= selSync;
  end

  always_comb begin
    strobe.loadActive = profChange | updRise;
    strobe.profIdx    = selSync;
  end

  // Data pacing pulse when not in single-tone mode (R9)
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      paceCnt  <= '0;
      dataPace <= 1'b0;
    end else begin
      paceCnt  <= (paceCnt == PACE_LAST) ? '0 : paceCnt + 1'b1;
      dataPace <= !singleTone && (paceCnt == PACE_LAST);
    end
  end

  initial begin
    a_r9_div_range: assert (PACE_DIV >= 2);
  end

  a_r3_change_tracked: assert property (@(posedge clk) disable iff (rst)
    profChange |=> (curProfile == $past(selSync)));

  a_r7_mode_blocks_strobe: assert property (@(posedge clk) disable iff (rst)
    (!singleTone && !profChange) |-> !strobe.loadActive);

  a_r9_pace_single_cycle: assert property (@(posedge clk) disable iff (rst)
    dataPace |=> !dataPace);

  a_r9_quiet_in_tone: assert property (@(posedge clk) disable iff (rst)
    $past(singleTone) |-> !dataPace);
endmodule

// File: rtl/prof_data.sv
module profData
  import profLoaderPkg::*;
#(
  parameter int TW_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wrEn,
  input  logic [PROF_IDX_W-1:0] wrAddr,
  input  logic [TW_W-1:0]       wrData,
  input  ctrlStrobe_t           strobe,
  output logic [TW_W-1:0]       activeWord,
  output logic [TW_W-1:0]       phase
);
  logic [TW_W-1:0] profBank [NUM_PROFILES];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      for (int i = 0; i < NUM_PROFILES; i++) profBank[i] <= '0;
    end else if (wrEn) begin
      profBank[wrAddr] <= wrData;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)                    activeWord <= '0;
    else if (strobe.loadActive) activeWord <= profBank[strobe.profIdx];
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) phase <= '0;
    else     phase <= phase + activeWord;
  end

  // Edits stay invisible unless control commits (R4)
  a_r4_word_hold: assert property (@(posedge clk) disable iff (rst)
    !strobe.loadActive |=> $stable(activeWord));
endmodule

// File: rtl/profile_tuning_loader.sv
module profile_tuning_loader
  import profLoaderPkg::*;
#(
  parameter int TW_W        = 32,
  parameter int PACE_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wrEn,
  input  logic [PROF_IDX_W-1:0] wrAddr,
  input  logic [TW_W-1:0]       wrData,
  input  logic                  selLow,
  input  logic                  selHigh,
  input  logic                  singleTone,
  input  logic                  updIn,
  output logic                  dataPace,
  output logic [TW_W-1:0]       activeTw,
  output logic [TW_W-1:0]       phaseOut
);
  ctrlStrobe_t strobe;

  profCtrl #(.SYNC_STAGES(SYNC_STAGES), .PACE_DIV(PACE_DIV)) ctrlInst (
    .clk(clk), .rst(rst), .selLow(selLow), .selHigh(selHigh),
    .singleTone(singleTone), .updIn(updIn), .strobe(strobe), .dataPace(dataPace)
  );

  profData #(.TW_W(TW_W)) dataInst (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strobe(strobe), .activeWord(activeTw), .phase(phaseOut)
  );

  a_r8_phase_slope: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (phaseOut - $past(phaseOut)) == $past(activeTw));

  a_r1_reset_zero: assert property (@(posedge clk)
    rst |-> (activeTw == '0 && phaseOut == '0 && !dataPace));
endmodule

// File: tb/profile_tuning_loader_test.sv
module profile_tuning_loader_test;
  localparam int PACE_DIV = 4;
  localparam logic [31:0] P0 = 32'h0000_1000, P1 = 32'h0123_4567,
                          P2 = 32'h89AB_CDEF, P3 = 32'hC000_0000;

  typedef struct packed { logic hi; logic lo; logic [31:0] word; } vec_t;
  localparam vec_t VECS [6] = '{
    '{1'b0, 1'b1, P1}, '{1'b1, 1'b0, P2}, '{1'b1, 1'b1, P3},
    '{1'b0, 1'b0, P0}, '{1'b1, 1'b0, P2}, '{1'b0, 1'b1, P1}};

  logic clk = 0, rst = 1, wrEn = 0, selLow = 0, selHigh = 0, singleTone = 1, updIn = 0;
  logic [1:0]  wrAddr = 0;
  logic [31:0] wrData = 0;
  logic        dataPace;
  logic [31:0] activeTw, phaseOut;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  profile_tuning_loader #(.PACE_DIV(PACE_DIV)) uut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .selLow(selLow), .selHigh(selHigh), .singleTone(singleTone), .updIn(updIn),
    .dataPace(dataPace), .activeTw(activeTw), .phaseOut(phaseOut));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeProf(input logic [1:0] a, input logic [31:0] d);
    wrEn = 1; wrAddr = a; wrData = d;
    tick(1);
    wrEn = 0;
  endtask

  task automatic pulseUpd();
    updIn = 1; tick(1); updIn = 0; tick(4);
  endtask

  task automatic checkStep(input string req);
    logic [31:0] p0, w0;
    p0 = phaseOut; w0 = activeTw;
    tick(1);
    check(req, phaseOut - p0, w0);
  endtask

  task automatic countPace(input string req, input int exp);
    int n = 0;
    for (int i = 0; i < 4 * PACE_DIV; i++) begin
      tick(1);
      if (dataPace) n++;
    end
    check(req, n, exp);
  endtask

  initial begin
    tick(3);
    check("R1 activeTw in reset", activeTw, 0);
    check("R1 phaseOut in reset", phaseOut, 0);
    check("R1 dataPace in reset", {31'b0, dataPace}, 0);
    rst = 0;
    selHigh = 1; selLow = 1; tick(4);
    check("R1 profile 3 cleared", activeTw, 0);
    check("R1 phase stays zero", phaseOut, 0);

    // R4: edit of the active profile waits for a commit
    writeProf(2'd3, P3); tick(4);
    check("R4 active edit held", activeTw, 0);
    pulseUpd();
    check("R5 strobe commits", activeTw, P3);
    writeProf(2'd0, P0); writeProf(2'd1, P1); writeProf(2'd2, P2);
    tick(3);
    check("R4 other slots no effect", activeTw, P3);

    // R2/R3/R8: table walk over select patterns
    for (int i = 0; i < 6; i++) begin
      selHigh = VECS[i].hi; selLow = VECS[i].lo;
      tick(4);
      check($sformatf("R2 R3 vector %0d", i), activeTw, VECS[i].word);
      checkStep($sformatf("R8 step vector %0d", i));
    end

    // R6: held strobe gives one commit
    writeProf(2'd1, 32'h0000_0AAA); tick(2);
    check("R4 before held strobe", activeTw, P1);
    updIn = 1; tick(6);
    check("R6 first edge commits", activeTw, 32'h0000_0AAA);
    writeProf(2'd1, 32'h0000_0BBB); tick(6);
    check("R6 held high no recommit", activeTw, 32'h0000_0AAA);
    updIn = 0; tick(4);
    check("R6 fall no commit", activeTw, 32'h0000_0AAA);
    pulseUpd();
    check("R6 new edge commits", activeTw, 32'h0000_0BBB);

    // R9 in single-tone mode
    countPace("R9 no pace in single tone", 0);

    // R7: strobe ignored outside single-tone mode
    singleTone = 0;
    writeProf(2'd1, 32'h0000_0CCC);
    pulseUpd(); tick(2);
    check("R7 strobe ignored", activeTw, 32'h0000_0BBB);
    countPace("R9 pace rate", 4);
    selHigh = 1; selLow = 0; tick(4);
    check("R3 change in other mode", activeTw, P2);
    selHigh = 0; selLow = 1; tick(4);
    check("R3 return loads edit", activeTw, 32'h0000_0CCC);

    // R8 wrap: 4 * 0xC0000000 is 0 modulo 2^32
    singleTone = 1;
    selHigh = 1; selLow = 1; tick(4);
    check("R8 wrap word", activeTw, P3);
    begin
      logic [31:0] ref0;
      ref0 = phaseOut;
      tick(4);
      check("R8 wrap returns", phaseOut, ref0);
    end
    checkStep("R8 wrap step");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule